// File: doc/BRIEF.md
# SPI Serial Clock and Select Timing Engine

This block produces the serial clock and the chip-select waveform for a single-target SPI master. The master runs from a system clock that is faster than the serial clock. A start pulse launches a transaction. The block then asserts select and waits a setup gap. It emits a requested number of serial clock pulses and waits a hold gap. Finally it releases select and pulses `done_o`. The low and high halves of every pulse are set separately, in system clocks. The setup and hold gaps come from small fixed tables picked by 2-bit codes.

A separate data-path sequencer uses the two strobes. `shift_o` marks each cycle where the next bit must be launched. `sample_o` marks each cycle where incoming data is captured. Only the two clock-polarity-equals-phase modes are supported. In both modes every pulse is a low half followed by a high half. The sample edge is therefore always the rising edge, and the launch point is the start of each low half. The mode bit only selects the level of the serial clock while no pulse is being emitted. All controls are plain level or pulse pins. There is no data stream at this edge, so there is no valid/ready handshake.

Top module: `spi_edge_timer`

## Requirements
- R1: While reset is held, `busy_o` and `done_o` are 0, `shift_o` and `sample_o` are 0, `cs_o` is at its inactive level and `sclk_o` is at the idle level of the current mode.
- R2: Outside pulses (idle, setup gap, hold gap), `sclk_o` equals the mode bit: 0 gives an idle-low clock, 1 gives an idle-high clock. During idle the live input is used.
- R3: While busy, `cs_o` equals the polarity bit captured at start (1 = active high, 0 = active low). While idle, `cs_o` is the inverse of the live polarity bit.
- R4: Each pulse is `cfg_lo_i` system clocks with `sclk_o`=0 followed by `cfg_hi_i` clocks with `sclk_o`=1. A field value of 0 means 16 clocks.
- R5: The setup gap from the first busy cycle to the first low half is 0, 2, 4 or 8 clocks for codes 0, 1, 2, 3 of `cfg_setup_i`.
- R6: The hold gap after the last high half is 1, 3, 5 or 9 clocks for codes 0, 1, 2, 3 of `cfg_hold_i`.
- R7: Exactly `npulse_i` pulses are emitted. A count of 0 goes straight from the setup gap to the hold gap.
- R8: `shift_o` is 1 only in the first cycle of each low half. `sample_o` is 1 only in the first cycle of each high half.
- R9: `busy_o` rises in the cycle after a start edge taken while idle and stays 1 through the hold gap. In the next cycle `busy_o` is 0, select is inactive and `done_o` is 1 for that single cycle.
- R10: A start request while busy has no effect. The waveform and the `done_o` timing are unchanged.
- R11: Changing any configuration input or `npulse_i` while busy has no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled on rising clock edges |
| npulse_i | input | PULSE_W | Number of serial clock pulses |
| cfg_mode3_i | input | 1 | Serial clock idle level (0 low, 1 high) |
| cfg_cs_act_high_i | input | 1 | Select polarity (1 active high) |
| cfg_lo_i | input | PH_W | Low half length in system clocks, 0 = 2^PH_W |
| cfg_hi_i | input | PH_W | High half length in system clocks, 0 = 2^PH_W |
| cfg_setup_i | input | 2 | Setup gap code |
| cfg_hold_i | input | 2 | Hold gap code |
| sclk_o | output | 1 | Serial clock |
| cs_o | output | 1 | Chip select |
| shift_o | output | 1 | Launch strobe |
| sample_o | output | 1 | Sample strobe |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default widths, PH_W=4 and PULSE_W=8. With PH_W=4 the 16-value phase fields can be covered completely.

The first sweep runs every pair of low and high lengths, including the 0-means-16 encoding, with two pulses per transaction. The second sweep runs every combination of mode, polarity, setup code and hold code with 0, 1 and 3 pulses. In every transaction the configuration inputs are scrambled and a second start is pulsed mid-way. The bench then compares all six outputs in every cycle against a position computed from the lengths.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_HOLD  = 3'd4
  } sseq_state_t;

  // Setup gap: code 0 skips the gap, otherwise 2^code clocks.
  function automatic logic [3:0] setup_clocks(input logic [1:0] code);
    logic [3:0] r;
    case (code)
      2'd0:    r = 4'd0;
      2'd1:    r = 4'd2;
      2'd2:    r = 4'd4;
      default: r = 4'd8;
    endcase
    return r;
  endfunction

  // Hold gap: 1, 3, 5 or 9 clocks.
  function automatic logic [3:0] hold_clocks(input logic [1:0] code);
    logic [3:0] r;
    case (code)
      2'd0:    r = 4'd1;
      2'd1:    r = 4'd3;
      2'd2:    r = 4'd5;
      default: r = 4'd9;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sseq_phase_timer.sv
module sseq_phase_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expire_o
);

  logic [W-1:0] cnt_q;

  // Loading len makes expire_o rise len cycles after the load edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/sseq_pulse_tally.sv
module sseq_pulse_tally #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] count_i,
  input  logic         dec_i,
  output logic         empty_o,
  output logic         last_o
);

  logic [W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load_i) begin
      left_q <= count_i;
    end else if (dec_i && left_q != '0) begin
      left_q <= left_q - W'(1);
    end
  end

  assign empty_o = (left_q == '0);
  assign last_o  = (left_q == W'(1));

endmodule

// File: rtl/sseq_outdec.sv
module sseq_outdec
  import sseq_pkg::*;
(
  input  sseq_state_t st_i,
  input  logic        idle_high_i,
  input  logic        act_high_i,
  input  logic        first_i,
  output logic        sclk_o,
  output logic        cs_o,
  output logic        shift_o,
  output logic        sample_o,
  output logic        busy_o
);

  always_comb begin
    case (st_i)
      ST_LOW:  sclk_o = 1'b0;
      ST_HIGH: sclk_o = 1'b1;
      default: sclk_o = idle_high_i;
    endcase
  end

  assign busy_o   = (st_i != ST_IDLE);
  assign cs_o     = busy_o ? act_high_i : ~act_high_i;
  assign shift_o  = (st_i == ST_LOW)  && first_i;
  assign sample_o = (st_i == ST_HIGH) && first_i;

endmodule

// File: rtl/spi_edge_timer.sv
module spi_edge_timer
  import sseq_pkg::*;
#(
  parameter int PULSE_W = 8,
  parameter int PH_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PULSE_W-1:0] npulse_i,
  input  logic               cfg_mode3_i,
  input  logic               cfg_cs_act_high_i,
  input  logic [PH_W-1:0]    cfg_lo_i,
  input  logic [PH_W-1:0]    cfg_hi_i,
  input  logic [1:0]         cfg_setup_i,
  input  logic [1:0]         cfg_hold_i,
  output logic               sclk_o,
  output logic               cs_o,
  output logic               shift_o,
  output logic               sample_o,
  output logic               busy_o,
  output logic               done_o
);

  // Timer width covers 2^PH_W and the 9-clock hold entry.
  localparam int TW = (PH_W + 1 > 4) ? PH_W + 1 : 4;

  function automatic logic [TW-1:0] half_clocks(input logic [PH_W-1:0] v);
    logic [TW-1:0] r;
    if (v == '0) r = TW'(1) << PH_W;
    else         r = TW'(v);
    return r;
  endfunction

  sseq_state_t st_q, st_d;

  logic            mode_q, pol_q;
  logic [PH_W-1:0] lo_q, hi_q;
  logic [1:0]      setup_q, hold_q;

  logic            idle;
  logic            take;
  logic            mode_e, pol_e;
  logic [PH_W-1:0] lo_e, hi_e;
  logic [1:0]      setup_e, hold_e;

  logic            ld;
  logic [TW-1:0]   ld_len;
  logic            tmr_exp;
  logic            fin;
  logic            hi_end;
  logic            tally_empty, tally_last;
  logic            first_q;
  logic            done_q;

  assign idle = (st_q == ST_IDLE);
  assign take = idle && start_i;

  // While idle the live inputs act; once started the captured copy does.
  assign mode_e  = idle ? cfg_mode3_i       : mode_q;
  assign pol_e   = idle ? cfg_cs_act_high_i : pol_q;
  assign lo_e    = idle ? cfg_lo_i          : lo_q;
  assign hi_e    = idle ? cfg_hi_i          : hi_q;
  assign setup_e = idle ? cfg_setup_i       : setup_q;
  assign hold_e  = idle ? cfg_hold_i        : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      pol_q   <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      setup_q <= '0;
      hold_q  <= '0;
    end else if (take) begin
      mode_q  <= cfg_mode3_i;
      pol_q   <= cfg_cs_act_high_i;
      lo_q    <= cfg_lo_i;
      hi_q    <= cfg_hi_i;
      setup_q <= cfg_setup_i;
      hold_q  <= cfg_hold_i;
    end
  end

  assign hi_end = (st_q == ST_HIGH) && tmr_exp;

  always_comb begin
    st_d = st_q;
    ld   = 1'b0;
    fin  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          ld = 1'b1;
          if (cfg_setup_i != 2'd0)   st_d = ST_SETUP;
          else if (npulse_i != '0)   st_d = ST_LOW;
          else                       st_d = ST_HOLD;
        end
      end
      ST_SETUP: begin
        if (tmr_exp) begin
          ld   = 1'b1;
          st_d = tally_empty ? ST_HOLD : ST_LOW;
        end
      end
      ST_LOW: begin
        if (tmr_exp) begin
          ld   = 1'b1;
          st_d = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tmr_exp) begin
          ld   = 1'b1;
          st_d = tally_last ? ST_HOLD : ST_LOW;
        end
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          fin  = 1'b1;
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (st_d)
      ST_SETUP: ld_len = TW'(setup_clocks(setup_e));
      ST_LOW:   ld_len = half_clocks(lo_e);
      ST_HIGH:  ld_len = half_clocks(hi_e);
      ST_HOLD:  ld_len = TW'(hold_clocks(hold_e));
      default:  ld_len = TW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= ld;
      done_q  <= fin;
    end
  end

  sseq_phase_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (ld),
    .len_i    (ld_len),
    .expire_o (tmr_exp)
  );

  sseq_pulse_tally #(.W(PULSE_W)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (take),
    .count_i (npulse_i),
    .dec_i   (hi_end),
    .empty_o (tally_empty),
    .last_o  (tally_last)
  );

  sseq_outdec u_out (
    .st_i        (st_q),
    .idle_high_i (mode_e),
    .act_high_i  (pol_e),
    .first_i     (first_q),
    .sclk_o      (sclk_o),
    .cs_o        (cs_o),
    .shift_o     (shift_o),
    .sample_o    (sample_o),
    .busy_o      (busy_o)
  );

  assign done_o = done_q;

endmodule

// File: rtl/sseq_chk.sv
module sseq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic sclk_o,
  input logic cs_o,
  input logic shift_o,
  input logic sample_o,
  input logic busy_o,
  input logic done_o
);

  // R8: the launch strobe only appears while the clock is low
  a_r8_shift_low: assert property (@(posedge clk) disable iff (!rst_n)
    shift_o |-> !sclk_o);

  // R8: the sample strobe only appears while the clock is high
  a_r8_sample_high: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> sclk_o);

  // R8: strobes and completion never coincide
  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_o, sample_o, done_o}));

  // R4: every rising clock edge inside a transaction is a sample edge
  a_r4_rise_is_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $rose(sclk_o)) |-> sample_o);

  // R3: select holds its level for the whole transaction
  a_r3_cs_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(cs_o));

  // R9: completion follows a busy cycle and is idle itself
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R10: a transaction begins only from a start seen while idle
  a_r10_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_i) && !$past(busy_o)));

endmodule

bind spi_edge_timer sseq_chk u_sseq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .sclk_o   (sclk_o),
  .cs_o     (cs_o),
  .shift_o  (shift_o),
  .sample_o (sample_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/spi_edge_timer_tb_top.sv
module spi_edge_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] npulse_i = '0;
  logic       cfg_mode3_i = 1'b1;
  logic       cfg_cs_act_high_i = 1'b1;
  logic [3:0] cfg_lo_i = 4'd1;
  logic [3:0] cfg_hi_i = 4'd1;
  logic [1:0] cfg_setup_i = 2'd0;
  logic [1:0] cfg_hold_i = 2'd0;
  logic sclk_o, cs_o, shift_o, sample_o, busy_o, done_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  spi_edge_timer #(.PULSE_W(8), .PH_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .npulse_i(npulse_i),
    .cfg_mode3_i(cfg_mode3_i), .cfg_cs_act_high_i(cfg_cs_act_high_i),
    .cfg_lo_i(cfg_lo_i), .cfg_hi_i(cfg_hi_i),
    .cfg_setup_i(cfg_setup_i), .cfg_hold_i(cfg_hold_i),
    .sclk_o(sclk_o), .cs_o(cs_o), .shift_o(shift_o), .sample_o(sample_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input string sig, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, sig, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // One transaction, checked cycle by cycle from the first busy cycle.
  task automatic run_txn(input int mode, input int pol, input int lo, input int hi,
                         input int su, input int ho, input int n);
    int lc, hc, sc, dc, per, tot;
    logic live_mode, live_pol;
    lc  = (lo == 0) ? 16 : lo;
    hc  = (hi == 0) ? 16 : hi;
    sc  = (su == 0) ? 0 : (1 << su);
    dc  = (ho == 3) ? 9 : 2 * ho + 1;
    per = lc + hc;
    tot = sc + n * per + dc;
    cfg_mode3_i       = mode[0];
    cfg_cs_act_high_i = pol[0];
    cfg_lo_i          = lo[3:0];
    cfg_hi_i          = hi[3:0];
    cfg_setup_i       = su[1:0];
    cfg_hold_i        = ho[1:0];
    npulse_i          = n[7:0];
    start_i           = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    live_mode = ~mode[0];
    live_pol  = ~pol[0];
    for (int j = 0; j <= tot; j++) begin
      if (j < tot) begin
        chk("R9,R10", "busy", busy_o, 1'b1);
        chk("R9,R10", "done", done_o, 1'b0);
        chk("R3,R11", "cs", cs_o, pol[0]);
        if (j < sc) begin
          chk("R5,R2", "sclk", sclk_o, mode[0]);
          chk("R8", "shift", shift_o, 1'b0);
          chk("R8", "sample", sample_o, 1'b0);
        end else if (j - sc < n * per) begin
          int r;
          r = (j - sc) % per;
          chk("R4,R7", "sclk", sclk_o, (r >= lc));
          chk("R8", "shift", shift_o, (r == 0));
          chk("R8", "sample", sample_o, (r == lc));
        end else begin
          chk("R6,R7", "sclk", sclk_o, mode[0]);
          chk("R8", "shift", shift_o, 1'b0);
          chk("R8", "sample", sample_o, 1'b0);
        end
      end else begin
        chk("R9", "busy", busy_o, 1'b0);
        chk("R9", "done", done_o, 1'b1);
        chk("R9,R3", "cs", cs_o, ~live_pol);
        chk("R2", "sclk", sclk_o, live_mode);
        chk("R8", "strobes", shift_o | sample_o, 1'b0);
      end
      if (j == 0) begin
        // R11: scramble every configuration input while busy
        cfg_mode3_i       = live_mode;
        cfg_cs_act_high_i = live_pol;
        cfg_lo_i          = cfg_lo_i ^ 4'd5;
        cfg_hi_i          = cfg_hi_i ^ 4'd9;
        cfg_setup_i       = ~cfg_setup_i;
        cfg_hold_i        = ~cfg_hold_i;
        npulse_i          = npulse_i + 8'd2;
      end
      if (j == tot / 2 && j < tot) start_i = 1'b1; // R10: start while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    // the cycle after done: idle, no restart from the ignored request
    chk("R10", "busy_after", busy_o, 1'b0);
    chk("R9", "done_after", done_o, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state with idle-high clock and active-high select
    chk("R1", "busy", busy_o, 1'b0);
    chk("R1", "done", done_o, 1'b0);
    chk("R1", "strobes", shift_o | sample_o, 1'b0);
    chk("R1", "sclk", sclk_o, 1'b1);
    chk("R1", "cs", cs_o, 1'b0);
    cfg_mode3_i = 1'b0;
    cfg_cs_act_high_i = 1'b0;
    #1;
    chk("R1", "sclk_mode0", sclk_o, 1'b0);
    chk("R1", "cs_low_active", cs_o, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "idle_sclk", sclk_o, 1'b0);

    // Sweep 1: every low/high length pair, two pulses
    for (int lo = 0; lo < 16; lo++) begin
      for (int hi = 0; hi < 16; hi++) begin
        run_txn((lo + hi) & 1, (lo >> 1) & 1, lo, hi, hi & 3, lo & 3, 2);
      end
    end
    // Sweep 2: every mode, polarity, setup and hold with 0, 1 and 3 pulses
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 2; p++)
        for (int su = 0; su < 4; su++)
          for (int ho = 0; ho < 4; ho++)
            for (int k = 0; k < 3; k++)
              run_txn(m, p, 1 + k, 2 + su, su, ho, (k == 2) ? 3 : k);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule